// File: doc/BRIEF.md
# Two-wire serial byte memory target

This block is the target side of a two-wire (I2C) link to a 256-byte memory. A fast system clock oversamples the SCL and SDA pins through two-flop synchronizers. START and STOP are found from the registered copies, and bytes are shifted in and out MSB first. The block pulls SDA low only through an active-high output enable, `sda_oe_o`. The bus pins themselves are open-drain and pulled up outside the block.

After a START the master sends a select byte: a 7-bit device code followed by a direction bit. A write command is a select byte, then one address byte, then data bytes. The data is collected in a small buffer and reaches the array only when programming finishes. A STOP after buffered data starts a programming interval of `PROG_CYCLES` system clocks, and the bus is ignored while it runs. A read returns bytes from the current address pointer, so a random read is a write command with an address, followed by a repeated START and a read select.

A write-lock input keeps the select and address bytes acknowledged but refuses data bytes.

Top module: `serial_mem_target`

## Requirements
- R1: After reset `sda_oe_o` and `busy_o` are both 0.
- R2: A START followed by a select byte whose upper 7 bits equal `DEV_CODE` is acknowledged on the 9th clock. A non-matching select byte is not acknowledged, and every later byte is ignored until the next START.
- R3: The byte after a write select (direction bit 0) is acknowledged and loads the address pointer.
- R4: While the lock is low, data bytes are acknowledged and buffered at consecutive addresses, up to `BUF_DEPTH` bytes per command. Later bytes are refused. The STOP that follows buffered data raises `busy_o` for `PROG_CYCLES` clocks, and the data enters the array when `busy_o` falls.
- R5: While `wr_lock_i` is 1, data bytes are not acknowledged, no programming starts, and memory keeps its contents.
- R6: While `busy_o` is 1, START, select and STOP on the bus are ignored and SDA is never pulled low.
- R7: After a read select (direction bit 1) the block sends `mem[pointer]` MSB first. A 0 bit pulls SDA low and a 1 bit releases it.
- R8: The pointer increments after every data byte, written or read with a master ACK, and wraps from 255 to 0.
- R9: During a read, a STOP after a master ACK does not end the read. The block restarts the current byte from its MSB on the next SCL fall. A STOP after a master no-ACK returns the block to standby.
- R10: `sda_oe_o` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock pin level |
| sda_i | input | 1 | Serial data pin level as seen on the wire |
| wr_lock_i | input | 1 | 1 refuses data bytes of write commands |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| busy_o | output | 1 | Programming interval in progress |

## Verification
The bench sends every one of the 128 select codes. A decoder that compared too few bits, or that went on listening after a mismatch, would acknowledge a wrong code.

Writes run across the 255-to-0 boundary and past the buffer size. An off-by-one in the pointer or the buffer count shows up as shifted read-back data or a wrong ACK on the 17th byte.

A select byte sent during programming checks that START is ignored while busy. A read that is cut by a STOP after an ACK has to resume the same byte intact, and the same read ended by a no-ACK has to leave the bus released.

// File: rtl/serial_mem_target.sv
module serial_mem_target #(
  parameter logic [6:0] DEV_CODE    = 7'h50,
  parameter int         PROG_CYCLES = 5000,
  parameter int         BUF_DEPTH   = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wr_lock_i,
  output logic sda_oe_o,
  output logic busy_o
);

  localparam int PW = $clog2(PROG_CYCLES + 1);
  localparam int BW = $clog2(BUF_DEPTH + 1);
  localparam int IW = $clog2(BUF_DEPTH);

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_ADDR, S_WDATA, S_RD, S_RNAK, S_PROG} state_t;

  state_t        state, nxt, nxt_c;
  logic [2:0]    scl_p, sda_p;
  logic [3:0]    bitcnt;
  logic [7:0]    sh, tx, addr;
  logic          mack, ack_c;
  logic [PW-1:0] pcnt;
  logic [BW-1:0] buf_cnt;
  logic [7:0]    mem     [256];
  logic [7:0]    buf_dat [BUF_DEPTH];
  logic [7:0]    buf_adr [BUF_DEPTH];

  wire scl_s = scl_p[1], scl_q = scl_p[2];
  wire sda_s = sda_p[1], sda_q = sda_p[2];
  wire start_c  = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_c   = scl_s & scl_q & ~sda_q & sda_s;
  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire active   = (state == S_DEV) || (state == S_ADDR) || (state == S_WDATA) || (state == S_RD);
  wire buf_push = scl_fall && bitcnt == 4'd8 && state == S_WDATA && !wr_lock_i
                  && buf_cnt < BW'(BUF_DEPTH);
  wire commit   = state == S_PROG && pcnt == '0;
  wire [7:0] rd_cur  = mem[addr];
  wire [7:0] rd_next = mem[addr + 8'd1];

  assign busy_o = state == S_PROG;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
    end

  always_comb begin
    ack_c = 1'b0;
    nxt_c = S_IDLE;
    case (state)
      S_DEV:   if (sh[7:1] == DEV_CODE) begin ack_c = 1'b1; nxt_c = sh[0] ? S_RD : S_ADDR; end
      S_ADDR:  begin ack_c = 1'b1; nxt_c = S_WDATA; end
      S_WDATA: begin ack_c = buf_push; nxt_c = S_WDATA; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (buf_push) begin
      buf_dat[buf_cnt[IW-1:0]] <= sh;
      buf_adr[buf_cnt[IW-1:0]] <= addr;
    end
    if (commit)
      for (int i = 0; i < BUF_DEPTH; i++)
        if (i < int'(buf_cnt)) mem[buf_adr[i]] <= buf_dat[i];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state    <= S_IDLE;
      nxt      <= S_IDLE;
      bitcnt   <= '0;
      sh       <= '0;
      tx       <= '0;
      addr     <= '0;
      mack     <= 1'b0;
      pcnt     <= '0;
      buf_cnt  <= '0;
      sda_oe_o <= 1'b0;
    end else if (state == S_PROG) begin
      if (commit) begin
        state   <= S_IDLE;
        buf_cnt <= '0;
      end else pcnt <= pcnt - PW'(1);
    end else if (start_c) begin
      state    <= S_DEV;
      bitcnt   <= '0;
      buf_cnt  <= '0;
      sda_oe_o <= 1'b0;
    end else if (stop_c) begin
      sda_oe_o <= 1'b0;
      bitcnt   <= '0;
      if (state == S_RD) state <= S_RD;
      else if (state == S_WDATA && buf_cnt != '0) begin
        state <= S_PROG;
        pcnt  <= PW'(PROG_CYCLES - 1);
      end else state <= S_IDLE;
    end else if (active) begin
      if (scl_rise) begin
        if (bitcnt < 4'd8) sh <= {sh[6:0], sda_s};
        if (bitcnt == 4'd8) mack <= ~sda_s;
        bitcnt <= bitcnt + 4'd1;
      end
      if (scl_fall) begin
        if (bitcnt == 4'd8) begin
          if (state == S_RD) sda_oe_o <= 1'b0;
          else begin
            sda_oe_o <= ack_c;
            nxt      <= nxt_c;
            if (state == S_ADDR) addr <= sh;
            if (buf_push) begin
              addr    <= addr + 8'd1;
              buf_cnt <= buf_cnt + BW'(1);
            end
          end
        end else if (bitcnt == 4'd9) begin
          bitcnt <= '0;
          if (state == S_RD) begin
            if (mack) begin
              addr     <= addr + 8'd1;
              tx       <= rd_next;
              sda_oe_o <= ~rd_next[7];
            end else begin
              state    <= S_RNAK;
              sda_oe_o <= 1'b0;
            end
          end else begin
            state    <= nxt;
            sda_oe_o <= (nxt == S_RD) ? ~rd_cur[7] : 1'b0;
            if (nxt == S_RD) tx <= rd_cur;
          end
        end else if (state == S_RD) sda_oe_o <= ~tx[3'd7 - bitcnt[2:0]];
      end
    end

  assert_oe_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe_o != $past(sda_oe_o)) |-> !$past(scl_s));

  assert_busy_from_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(stop_c));

  assert_busy_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !sda_oe_o);

  assert_lock_refuses_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lock_i && $past(wr_lock_i) && state == S_WDATA && $past(state) == S_WDATA) |-> !sda_oe_o);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && $past(state) == S_IDLE) |-> !sda_oe_o);

endmodule

// File: tb/serial_mem_target_bench.sv
module serial_mem_target_bench;
  localparam int         Q    = 5;
  localparam int         PROG = 400;
  localparam logic [6:0] DEV  = 7'h50;

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1, wr_lock = 1'b0;
  logic sda_oe, busy;
  wire  sda_bus = m_sda & ~sda_oe;
  int   checks = 0, errors = 0, viol = 0;
  logic [7:0] exp_mem [256];
  bit         valid   [256];
  logic       prev_oe = 1'b0;

  always #5 clk = ~clk;

  serial_mem_target #(.DEV_CODE(DEV), .PROG_CYCLES(PROG), .BUF_DEPTH(16)) u_serial_mem_target (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .wr_lock_i(wr_lock),
    .sda_oe_o(sda_oe), .busy_o(busy));

  always @(negedge clk) begin
    if (rst_n && sda_oe !== prev_oe && m_scl) viol++;
    prev_oe = sda_oe;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hold();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1; hold(); m_scl = 1; hold(); m_sda = 0; hold(); m_scl = 0; hold();
  endtask

  task automatic bus_stop();
    m_sda = 0; hold(); m_scl = 1; hold(); m_sda = 1; hold();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; hold(); m_scl = 1; hold(); hold(); m_scl = 0; hold();
    end
    m_sda = 1; hold(); m_scl = 1; hold(); ack = (sda_bus == 1'b0); hold(); m_scl = 0; hold();
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1; hold(); m_scl = 1; hold(); d[i] = sda_bus; hold(); m_scl = 0; hold();
    end
    m_sda = mack ? 1'b0 : 1'b1; hold(); m_scl = 1; hold(); hold(); m_scl = 0; hold(); m_sda = 1;
  endtask

  function automatic logic [7:0] pat(input logic [7:0] b, input int i);
    return 8'(int'(b) * 3 + i * 29 + 91);
  endfunction

  task automatic write_seq(input logic [7:0] base, input int n, input bit lock,
                           input bit probe, input bit timeit);
    bit a;
    int cnt;
    wr_lock = lock;
    bus_start();
    send_byte({DEV, 1'b0}, a); chk(a, "R2 write select ack", a, 1);
    send_byte(base, a);        chk(a, "R3 address ack", a, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(pat(base, i), a);
      if (lock) chk(!a, "R5 locked data refused", a, 0);
      else begin
        chk(a == (i < 16), "R4 data ack vs buffer depth", a, i < 16);
        if (i < 16) begin
          exp_mem[8'(base + i)] = pat(base, i);
          valid[8'(base + i)]   = 1'b1;
        end
      end
    end
    bus_stop();
    if (lock) chk(busy == 1'b0, "R5 no programming when locked", busy, 0);
    else chk(busy == 1'b1, "R4 busy after stop", busy, 1);
    if (probe) begin
      bus_start();
      send_byte({DEV, 1'b0}, a);
      chk(!a, "R6 select ignored while busy", a, 0);
      bus_stop();
    end
    cnt = 0;
    while (busy && cnt < 2 * PROG) begin @(negedge clk); cnt++; end
    if (timeit) chk(cnt >= PROG - 6 && cnt <= PROG, "R4 programming length", cnt, PROG);
    wr_lock = 1'b0;
  endtask

  task automatic read_seq(input logic [7:0] base, input int n);
    bit a;
    logic [7:0] d;
    bus_start();
    send_byte({DEV, 1'b0}, a); chk(a, "R2 select ack", a, 1);
    send_byte(base, a);        chk(a, "R3 address ack", a, 1);
    bus_start();
    send_byte({DEV, 1'b1}, a); chk(a, "R7 read select ack", a, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, d);
      if (valid[8'(base + i)])
        chk(d == exp_mem[8'(base + i)], i == 0 ? "R7 read data" : "R8 sequential read data",
            d, exp_mem[8'(base + i)]);
    end
    bus_stop();
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit a;
    logic [7:0] d;
    for (int i = 0; i < 256; i++) valid[i] = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(sda_oe == 1'b0, "R1 sda_oe after reset", sda_oe, 0);
    chk(busy == 1'b0, "R1 busy after reset", busy, 0);

    for (int c = 0; c < 128; c++) begin
      bus_start();
      send_byte({7'(c), 1'b0}, a);
      chk(a == (7'(c) == DEV), "R2 select code match", a, 7'(c) == DEV);
      if (7'(c) != DEV && c % 16 == 0) begin
        send_byte({DEV, 1'b0}, a);
        chk(!a, "R2 ignored after mismatch", a, 0);
      end
      bus_stop();
    end

    write_seq(8'h10, 4, 1'b0, 1'b0, 1'b1);
    write_seq(8'hFA, 12, 1'b0, 1'b1, 1'b0);
    write_seq(8'h40, 17, 1'b0, 1'b0, 1'b0);
    write_seq(8'h10, 3, 1'b1, 1'b0, 1'b0);
    for (int k = 0; k < 6; k++) write_seq(8'(k * 40 + 3), 5, 1'b0, 1'b0, 1'b0);
    write_seq(8'h80, 3, 1'b0, 1'b0, 1'b0);

    read_seq(8'h10, 4);
    read_seq(8'hFA, 12);
    read_seq(8'h40, 16);
    for (int k = 0; k < 6; k++) read_seq(8'(k * 40 + 3), 5);

    bus_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(8'h80, a);
    bus_start();
    send_byte({DEV, 1'b1}, a); chk(a, "R7 read select ack", a, 1);
    recv_byte(1'b1, d);        chk(d == exp_mem[8'h80], "R7 first byte", d, exp_mem[8'h80]);
    bus_stop();
    m_scl = 0; hold();
    recv_byte(1'b0, d);
    chk(d == exp_mem[8'h81], "R9 read resumes after stop following ack", d, exp_mem[8'h81]);
    bus_stop();
    m_scl = 0; hold();
    recv_byte(1'b0, d);
    chk(d == 8'hFF, "R9 standby after no-ack stop", d, 8'hFF);
    bus_stop();
    chk(busy == 1'b0, "R9 no programming after read", busy, 0);

    chk(viol == 0, "R10 sda_oe changed while SCL high", viol, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule